// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms the 20-bit physical address of every bus access from a 16-bit offset and one of four 16-bit segment base registers. The chosen base is moved up by four bit positions and added to the offset, and any carry above bit 19 is dropped, so addresses wrap inside the 1 MB space. The segment is picked from the kind of access. Instruction fetches always use the code segment, and their offset comes from an internal instruction offset counter. Stack accesses always use the stack segment. Data accesses use the data segment by default, and a valid override code can replace it with any of the four segments.

The surrounding core loads the extra, stack and data segments through a general load port. The code segment and the instruction offset change only through a far transfer port, which writes both in the same cycle. The instruction offset steps by one on each fetch. The address and the code of the segment used both appear one clock after the access is presented.

Top module: `seg_addr_gen`

## Requirements
- R1: The address equals the selected segment value times 16 plus the offset. Segment 1234h with offset 5678h gives 179B8h.
- R2: A sum above 20 bits wraps modulo 2^20. For example, FFFFh:0010h gives 00000h.
- R3: A fetch (acc_type 00) uses the code segment and the instruction offset register. It reports pa_seg 01 and ignores acc_off, ovr_valid and ovr_sel.
- R4: A stack access (acc_type 01) uses the stack segment and reports pa_seg 10, whatever the override inputs are.
- R5: A data access (acc_type 10 or 11) with ovr_valid low uses the data segment and reports pa_seg 11.
- R6: A data access with ovr_valid high uses the segment named by ovr_sel, coded 00 extra, 01 code, 10 stack, 11 data. pa_seg carries the same code.
- R7: When ld_en is high, ld_val is written into the segment named by ld_sel, using the same codes as R6. A general load with ld_sel 01 (code) has no effect.
- R8: When far_en is high, far_seg is loaded into the code segment and far_off into the instruction offset in the same cycle. This load takes precedence over the fetch increment.
- R9: Each fetch without a far transfer advances the instruction offset by one, modulo 2^16.
- R10: Synchronous reset sets the code segment to FFFFh, sets the instruction offset and the other segments to 0000h, and clears pa_valid, pa_addr and pa_seg.
- R11: pa_valid follows acc_valid one cycle later. The address is computed from register values as they stood before that cycle's writes. With acc_valid low, pa_addr and pa_seg hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_type | input | 2 | 00 fetch, 01 stack, 10/11 data |
| acc_off | input | 16 | Offset for stack and data accesses |
| ovr_valid | input | 1 | Segment override request |
| ovr_sel | input | 2 | Override segment code |
| ld_en | input | 1 | General segment load |
| ld_sel | input | 2 | Segment code for the general load |
| ld_val | input | 16 | Value for the general load |
| far_en | input | 1 | Far control transfer update |
| far_seg | input | 16 | New code segment value |
| far_off | input | 16 | New instruction offset value |
| pa_valid | output | 1 | Registered access valid |
| pa_addr | output | 20 | Registered physical address |
| pa_seg | output | 2 | Code of the segment used |

## Verification
Directed accesses cover the reference pair 1234h:5678h, the top-of-space wrap, a blocked general load of the code segment, a far transfer that coincides with a fetch, and an instruction offset that rolls over from FFFFh. Together these separate a plain add from a shift-and-add, a wrapping sum from a saturating one, and old register values from freshly written ones. Seeded random cycles then mix the three access types with random override requests and random loads. This shows whether an override leaks into fetch or stack accesses and whether each override code reaches the right register. A bench model predicts every address.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int PA_W    = SEG_W + SHIFT;
  localparam int NSEG    = 4;
  localparam int IDX_W   = $clog2(NSEG);

  typedef enum logic [IDX_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_idx_t;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_STACK = 2'b01,
    ACC_DATA  = 2'b10,
    ACC_DATA2 = 2'b11
  } acc_kind_t;

  // Base shifted up, offset zero-extended, carry past the top bit dropped.
  function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] shifted;
    logic [PA_W-1:0] ext_off;
    shifted = {base, {SHIFT{1'b0}}};
    ext_off = PA_W'(off);
    return shifted + ext_off;
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int              W      = SEG_W,
  parameter logic [SEG_W-1:0] CS_RST = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_en,
  input  logic [IDX_W-1:0]       ld_sel,
  input  logic [W-1:0]           ld_val,
  input  logic                   far_en,
  input  logic [W-1:0]           far_seg,
  output logic [NSEG-1:0][W-1:0] seg_q,
  output logic                   cs_ld_blocked
);
  logic [NSEG-1:0] wr_hit;

  assign cs_ld_blocked = ld_en && (ld_sel == SEG_CODE);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    if (i == int'(SEG_CODE)) begin : g_code
      assign wr_hit[i] = far_en;
      always_ff @(posedge clk) begin
        if (rst)          seg_q[i] <= W'(CS_RST);
        else if (far_en)  seg_q[i] <= far_seg;
      end
    end else begin : g_plain
      assign wr_hit[i] = ld_en && (ld_sel == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (rst)            seg_q[i] <= '0;
        else if (wr_hit[i]) seg_q[i] <= ld_val;
      end
    end
  end

  AST_CS_ONLY_FAR: assert property (@(posedge clk) disable iff (rst)
    !far_en |=> $stable(seg_q[SEG_CODE])); // R7
  AST_FAR_CS_LOAD: assert property (@(posedge clk) disable iff (rst)
    far_en |=> seg_q[SEG_CODE] == $past(far_seg)); // R8
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_hit[SEG_DATA:SEG_STACK]) <= 1); // R7
endmodule

// File: rtl/ip_counter.sv
module ip_counter
  import seg_addr_pkg::*;
#(
  parameter int W = OFF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fetch_evt,
  input  logic         far_en,
  input  logic [W-1:0] far_off,
  output logic [W-1:0] ip_q
);
  logic step_evt;
  assign step_evt = fetch_evt && !far_en;

  always_ff @(posedge clk) begin
    if (rst)           ip_q <= '0;
    else if (far_en)   ip_q <= far_off;
    else if (step_evt) ip_q <= ip_q + W'(1);
  end

  AST_IP_STEP: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> ip_q == W'($past(ip_q) + W'(1))); // R9
  AST_IP_FAR: assert property (@(posedge clk) disable iff (rst)
    far_en |=> ip_q == $past(far_off)); // R8
  AST_IP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!fetch_evt && !far_en) |=> $stable(ip_q)); // R9
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0]       acc_type,
  input  logic             ovr_valid,
  input  logic [IDX_W-1:0] ovr_sel,
  output seg_idx_t         sel_idx,
  output logic             is_fetch
);
  always_comb begin
    is_fetch = 1'b0;
    unique case (acc_kind_t'(acc_type))
      ACC_FETCH: begin
        sel_idx  = SEG_CODE;
        is_fetch = 1'b1;
      end
      ACC_STACK: sel_idx = SEG_STACK;
      default:   sel_idx = ovr_valid ? seg_idx_t'(ovr_sel) : SEG_DATA;
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic [1:0]  acc_type,
  input  logic [15:0] acc_off,
  input  logic        ovr_valid,
  input  logic [1:0]  ovr_sel,
  input  logic        ld_en,
  input  logic [1:0]  ld_sel,
  input  logic [15:0] ld_val,
  input  logic        far_en,
  input  logic [15:0] far_seg,
  input  logic [15:0] far_off,
  output logic        pa_valid,
  output logic [19:0] pa_addr,
  output logic [1:0]  pa_seg
);
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic                       cs_ld_blocked;
  logic [OFF_W-1:0]           ip_q;
  seg_idx_t                   sel_idx;
  logic                       is_fetch;
  logic                       fetch_evt;
  logic [OFF_W-1:0]           eff_off;
  logic [SEG_W-1:0]           base_val;

  seg_select u_sel (
    .acc_type (acc_type),
    .ovr_valid(ovr_valid),
    .ovr_sel  (ovr_sel),
    .sel_idx  (sel_idx),
    .is_fetch (is_fetch)
  );

  assign fetch_evt = acc_valid && is_fetch;

  seg_bank #(.W(SEG_W), .CS_RST('1)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .ld_en        (ld_en),
    .ld_sel       (ld_sel),
    .ld_val       (ld_val),
    .far_en       (far_en),
    .far_seg      (far_seg),
    .seg_q        (seg_q),
    .cs_ld_blocked(cs_ld_blocked)
  );

  ip_counter #(.W(OFF_W)) u_ip (
    .clk      (clk),
    .rst      (rst),
    .fetch_evt(fetch_evt),
    .far_en   (far_en),
    .far_off  (far_off),
    .ip_q     (ip_q)
  );

  assign eff_off  = is_fetch ? ip_q : acc_off;
  assign base_val = seg_q[sel_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_valid <= 1'b0;
      pa_addr  <= '0;
      pa_seg   <= '0;
    end else begin
      pa_valid <= acc_valid;
      if (acc_valid) begin
        pa_addr <= phys_addr(base_val, eff_off);
        pa_seg  <= sel_idx;
      end
    end
  end

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_type == 2'b00) |=> pa_seg == SEG_CODE); // R3
  AST_STACK_SS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_type == 2'b01) |=> pa_seg == SEG_STACK); // R4
  AST_DATA_DEF: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_type[1] && !ovr_valid) |=> pa_seg == SEG_DATA); // R5
  AST_DATA_OVR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_type[1] && ovr_valid) |=> pa_seg == $past(ovr_sel)); // R6
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> pa_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!pa_valid && $stable(pa_addr) && $stable(pa_seg))); // R11
  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (cs_ld_blocked && !far_en) |=> $stable(seg_q[SEG_CODE])); // R7
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, ovr_valid, ld_en, far_en;
  logic [1:0]  acc_type, ovr_sel, ld_sel;
  logic [15:0] acc_off, ld_val, far_seg, far_off;
  logic        pa_valid;
  logic [19:0] pa_addr;
  logic [1:0]  pa_seg;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] m_seg [4];
  logic [15:0] m_ip;
  logic [19:0] m_addr;
  logic [1:0]  m_sidx;

  always #4 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_type(acc_type),
    .acc_off(acc_off), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .far_en(far_en),
    .far_seg(far_seg), .far_off(far_off), .pa_valid(pa_valid),
    .pa_addr(pa_addr), .pa_seg(pa_seg)
  );

  function automatic logic [19:0] ref_addr(input logic [15:0] s, input logic [15:0] o);
    longint unsigned sum;
    sum = longint'(s) * 16 + longint'(o);
    return 20'(sum % 1048576);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] t, input logic [15:0] off,
                     input logic ov, input logic [1:0] os,
                     input logic le, input logic [1:0] ls, input logic [15:0] lv,
                     input logic fe, input logic [15:0] fs, input logic [15:0] fo,
                     input string req);
    logic [1:0]  si;
    logic [15:0] eo;
    acc_valid = v; acc_type = t; acc_off = off; ovr_valid = ov; ovr_sel = os;
    ld_en = le; ld_sel = ls; ld_val = lv; far_en = fe; far_seg = fs; far_off = fo;
    if (t == 2'b00)      si = 2'b01;
    else if (t == 2'b01) si = 2'b10;
    else                 si = ov ? os : 2'b11;
    eo = (t == 2'b00) ? m_ip : off;
    if (v) begin
      m_addr = ref_addr(m_seg[si], eo);
      m_sidx = si;
    end
    @(posedge clk);
    if (fe) begin
      m_seg[1] = fs;
      m_ip     = fo;
    end else if (v && t == 2'b00) begin
      m_ip = m_ip + 16'd1;
    end
    if (le && ls != 2'b01) m_seg[ls] = lv;
    @(negedge clk);
    chk(pa_valid == v, {req, " R11 valid"}, pa_valid, v);
    chk(pa_addr == m_addr, {req, " R1 addr"}, pa_addr, m_addr);
    chk(pa_seg == m_sidx, {req, " seg"}, pa_seg, m_sidx);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 2'b00, 16'h0, 1'b0, 2'b00, 1'b0, 2'b00, 16'h0, 1'b0, 16'h0, 16'h0, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    acc_valid = 0; acc_type = 0; acc_off = 0; ovr_valid = 0; ovr_sel = 0;
    ld_en = 0; ld_sel = 0; ld_val = 0; far_en = 0; far_seg = 0; far_off = 0;
    m_seg[0] = 16'h0; m_seg[1] = 16'hFFFF; m_seg[2] = 16'h0; m_seg[3] = 16'h0;
    m_ip = 16'h0; m_addr = 20'h0; m_sidx = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: outputs cleared by reset
    chk(pa_valid == 1'b0, "R10 pa_valid", pa_valid, 0);
    chk(pa_addr == 20'h0, "R10 pa_addr", pa_addr, 0);
    chk(pa_seg == 2'b00, "R10 pa_seg", pa_seg, 0);
    // R10/R3: first fetch from FFFF:0000 ignoring offset and override
    cyc(1, 2'b00, 16'h1234, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R10 R3 fetch");
    chk(pa_addr == 20'hFFFF0, "R10 reset fetch addr", pa_addr, 20'hFFFF0);
    // R5: data default with DS at reset value
    cyc(1, 2'b10, 16'hABCD, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R10 R5 data");
    // R1: reference pair
    cyc(0, 0, 0, 0, 0, 1, 2'b11, 16'h1234, 0, 0, 0, "R7 load DS");
    cyc(1, 2'b11, 16'h5678, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R1 R5 ref");
    chk(pa_addr == 20'h179B8, "R1 ref pair", pa_addr, 20'h179B8);
    // R2: wrap
    cyc(0, 0, 0, 0, 0, 1, 2'b00, 16'hFFFF, 0, 0, 0, "R7 load ES");
    cyc(1, 2'b10, 16'h0010, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R2 R6 wrap");
    chk(pa_addr == 20'h00000, "R2 wrap", pa_addr, 0);
    // R7: blocked load of code segment
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 16'h4444, 0, 0, 0, "R7 cs load");
    cyc(1, 2'b10, 16'h0000, 1, 2'b01, 0, 0, 0, 0, 0, 0, "R7 R6 cs read");
    chk(pa_addr == 20'hFFFF0, "R7 cs unchanged", pa_addr, 20'hFFFF0);
    // R4: stack ignores override
    cyc(0, 0, 0, 0, 0, 1, 2'b10, 16'h2000, 0, 0, 0, "R7 load SS");
    cyc(1, 2'b01, 16'h0042, 1, 2'b11, 0, 0, 0, 0, 0, 0, "R4 stack");
    chk(pa_addr == 20'h20042 && pa_seg == 2'b10, "R4 stack ovr ignored", pa_addr, 20'h20042);
    // R8: far transfer coinciding with a fetch
    cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 1, 16'h3000, 16'hFFFF, "R8 far+fetch");
    cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 R9 after far");
    chk(pa_addr == 20'h3FFFF, "R8 far target", pa_addr, 20'h3FFFF);
    // R9: offset wrap
    cyc(1, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 ip wrap");
    chk(pa_addr == 20'h30000, "R9 ip wrap", pa_addr, 20'h30000);
    // R11: same-cycle write uses old value, then idle hold
    cyc(1, 2'b10, 16'h0001, 0, 0, 1, 2'b11, 16'h0100, 0, 0, 0, "R11 old value");
    chk(pa_addr == 20'h12341, "R11 old DS", pa_addr, 20'h12341);
    idle("R11 hold");
    cyc(1, 2'b10, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "R11 new value");
    chk(pa_addr == 20'h01001, "R11 new DS", pa_addr, 20'h01001);
    // Random phase
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic fe;
      fe = ($urandom % 16) == 0;
      cyc(($urandom % 4) != 0, 2'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
          1'($urandom), 2'($urandom), 16'($urandom), fe, 16'($urandom),
          (($urandom % 4) == 0) ? 16'hFFFE : 16'($urandom), "R3 R4 R5 R6 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule